// File: doc/BRIEF.md
# Fractional Dual-Modulus Clock Divider

This block derives a slow clock from a fast master clock with a frequency resolution finer than one part per million. Integer division alone gives coarse steps. Here each divider period lasts either N or N+1 master cycles. A 20-bit phase accumulator advances once per period by a programmed fraction, and its carry out picks the longer period. Over many periods the average division ratio is N plus the fraction divided by 2^20. For example, a division of 480.0096 from a 24 MHz master clock gives 49.999 kHz. A fraction near zero rarely lengthens a period. A fraction near one lengthens almost every period.

The divider runs at twice the wanted output rate, and the output clock toggles on every terminal count, so both of its edges are produced. At each terminal count the block also exports the top four accumulator bits as a phase code. The code is a binary fraction of one master period. A separate 16x edge generator can use it to place the edge inside that period. A new integer or fraction is written through a load strobe into holding registers. It takes effect only at the next period boundary, so a period already in progress is never cut short or stretched.

Top module: `fnd_divider`

## Requirements
- R1: While rst_n is low, tc_pulse, phase_code and clk_out are all 0. The first terminal count follows on the first clock edge after reset is released.
- R2: The interval between two terminal counts is the active integer plus the carry. The carry comes out of the 20-bit accumulator when the active fraction is added to it at the first of those two terminal counts. The accumulator resets to 0.
- R3: tc_pulse is high for exactly one clock cycle per period.
- R4: phase_code changes only in the cycle in which tc_pulse is high. It then holds bits 19..16 of the accumulator value just updated.
- R5: clk_out inverts in each cycle in which tc_pulse is high and holds its value in every other cycle.
- R6: An integer value below 2 (0 or 1) is treated as 2.
- R7: The integer and fraction sampled with cfg_load high take effect at the first terminal count after the load edge. The period in progress at the load keeps its old length. Before any load, the integer and fraction come from the parameters DEF_INT and DEF_FRAC.
- R8: A fraction of 0 gives exactly N cycles every period. Fraction 0xFFFFF with N = 4095 gives periods of 4096 cycles. The 12-bit integer range thus extends to the 13-bit period length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_int | input | 12 | Integer division value N (values below 2 are treated as 2) |
| cfg_frac | input | 20 | Fraction added to the accumulator each period |
| cfg_load | input | 1 | Strobe: capture cfg_int and cfg_frac for the next period boundary |
| tc_pulse | output | 1 | One-cycle terminal-count pulse at the end of each period |
| phase_code | output | 4 | Top accumulator bits, updated together with tc_pulse |
| clk_out | output | 1 | Output clock, toggling on each terminal count |

## Verification
tc_pulse, phase_code and clk_out all come from registers loaded on the clock edge at which the internal count reaches zero. All three therefore change on the same edge, one cycle after that count state. The bench samples them on the falling edge and measures each interval as the difference between the cycle numbers of two consecutive pulses. It predicts the interval as N plus the difference of floor(k·F/2^20) between consecutive periods, and the phase as bits 19..16 of k·F mod 2^20. A load is applied on the cycle right after a pulse. The bench then expects the unchanged old length for the current interval and the new values from the next pulse onward.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int FND_INT_W  = 12;
  localparam int FND_FRAC_W = 20;
  localparam int FND_PH_W   = 4;
  localparam int FND_MIN_DIV = 2;
endpackage

// File: rtl/fnd_shadow.sv
module fnd_shadow #(
  parameter int INT_W    = fnd_pkg::FND_INT_W,
  parameter int FRAC_W   = fnd_pkg::FND_FRAC_W,
  parameter int MIN_DIV  = fnd_pkg::FND_MIN_DIV,
  parameter int DEF_INT  = 16,
  parameter int DEF_FRAC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic              cfg_load,
  input  logic              tc_now,
  output logic [INT_W-1:0]  eff_int,
  output logic [FRAC_W-1:0] eff_frac,
  output logic [INT_W-1:0]  act_int
);
  localparam logic [INT_W-1:0]  MIN_V  = INT_W'(MIN_DIV);
  localparam logic [INT_W-1:0]  RST_I  = INT_W'(DEF_INT);
  localparam logic [FRAC_W-1:0] RST_F  = FRAC_W'(DEF_FRAC);

  logic [INT_W-1:0]  pend_int;
  logic [FRAC_W-1:0] pend_frac;
  logic              pend_vld;
  logic [FRAC_W-1:0] act_frac;
  logic [INT_W-1:0]  cfg_int_cl;

  // small divide values would give a zero-length count; raise them
  always_comb cfg_int_cl = (cfg_int < MIN_V) ? MIN_V : cfg_int;

  // values used at the current terminal count
  always_comb begin
    eff_int  = pend_vld ? pend_int  : act_int;
    eff_frac = pend_vld ? pend_frac : act_frac;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_int  <= MIN_V;
      pend_frac <= '0;
      pend_vld  <= 1'b0;
      act_int   <= (RST_I < MIN_V) ? MIN_V : RST_I;
      act_frac  <= RST_F;
    end else begin
      if (tc_now) begin
        act_int  <= eff_int;
        act_frac <= eff_frac;
      end
      if (cfg_load) begin
        pend_int  <= cfg_int_cl;
        pend_frac <= cfg_frac;
        pend_vld  <= 1'b1;
      end else if (tc_now) begin
        pend_vld  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fnd_nco.sv
module fnd_nco #(
  parameter int FRAC_W = fnd_pkg::FND_FRAC_W,
  parameter int PH_W   = fnd_pkg::FND_PH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FRAC_W-1:0] incr,
  output logic              carry,
  output logic [PH_W-1:0]   phase_code
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    sum   = {1'b0, acc} + {1'b0, incr};
    carry = sum[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      phase_code <= '0;
    end else if (step) begin
      acc        <= sum[FRAC_W-1:0];
      phase_code <= sum[FRAC_W-1 -: PH_W];
    end
  end
endmodule

// File: rtl/fnd_counter.sv
module fnd_counter #(
  parameter int INT_W = fnd_pkg::FND_INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] eff_int,
  input  logic             carry,
  output logic             tc_now,
  output logic             tc_pulse
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  always_comb begin
    tc_now = (cnt == '0);
    reload = {1'b0, eff_int} + CNT_W'(carry) - CNT_W'(1);
  end

  // reset to zero so the first period boundary is the first edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= tc_now;
      cnt      <= tc_now ? reload : cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fnd_toggle.sv
module fnd_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_now,
  output logic clk_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)      clk_out <= 1'b0;
    else if (tc_now) clk_out <= ~clk_out;
  end
endmodule

// File: rtl/fnd_divider.sv
module fnd_divider #(
  parameter int INT_W    = fnd_pkg::FND_INT_W,
  parameter int FRAC_W   = fnd_pkg::FND_FRAC_W,
  parameter int PH_W     = fnd_pkg::FND_PH_W,
  parameter int DEF_INT  = 16,
  parameter int DEF_FRAC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic              cfg_load,
  output logic              tc_pulse,
  output logic [PH_W-1:0]   phase_code,
  output logic              clk_out
);
  logic              tc_now;
  logic              carry;
  logic [INT_W-1:0]  eff_int;
  logic [FRAC_W-1:0] eff_frac;
  logic [INT_W-1:0]  act_int;

  fnd_shadow #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_DIV(fnd_pkg::FND_MIN_DIV),
    .DEF_INT(DEF_INT), .DEF_FRAC(DEF_FRAC)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .cfg_int(cfg_int), .cfg_frac(cfg_frac),
    .cfg_load(cfg_load), .tc_now(tc_now), .eff_int(eff_int),
    .eff_frac(eff_frac), .act_int(act_int)
  );

  fnd_nco #(.FRAC_W(FRAC_W), .PH_W(PH_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .step(tc_now), .incr(eff_frac),
    .carry(carry), .phase_code(phase_code)
  );

  fnd_counter #(.INT_W(INT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .eff_int(eff_int), .carry(carry),
    .tc_now(tc_now), .tc_pulse(tc_pulse)
  );

  fnd_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .tc_now(tc_now), .clk_out(clk_out)
  );
endmodule

// File: rtl/fnd_checker.sv
module fnd_checker #(
  parameter int INT_W = fnd_pkg::FND_INT_W,
  parameter int PH_W  = fnd_pkg::FND_PH_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tc_pulse,
  input logic [PH_W-1:0]  phase_code,
  input logic             clk_out,
  input logic [INT_W-1:0] act_int
);
  localparam int GAP_W = INT_W + 2;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'((1 << INT_W));

  logic [GAP_W-1:0] gap;
  logic             seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tc_pulse) begin
      gap  <= GAP_W'(1);
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap  <= gap + GAP_W'(1);
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  assert_toggle_on_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (clk_out != $past(clk_out)));

  assert_hold_off_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_pulse |-> $stable(clk_out));

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_pulse |-> $stable(phase_code));

  assert_min_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_int >= INT_W'(2));

  assert_gap_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && seen) |-> (gap >= GAP_W'(2) && gap <= GAP_MAX));
endmodule

bind fnd_divider fnd_checker #(.INT_W(INT_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tc_pulse(tc_pulse), .phase_code(phase_code),
  .clk_out(clk_out), .act_int(act_int)
);

// File: tb/sim_fnd_divider.sv
`timescale 1ns/1ps
module sim_fnd_divider;
  localparam int DEF_N = 16;
  localparam int NV = 8;
  localparam int VN [NV] = '{5, 5, 3, 7, 0, 1, 480, 4095};
  localparam int VF [NV] = '{0, 'h80000, 'hFFFFF, 'h30000, 'h40000, 'hC0000, 10066, 'hFFFFF};
  localparam int VK [NV] = '{4, 6, 5, 8, 6, 6, 3, 2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_int = '0;
  logic [19:0] cfg_frac = '0;
  logic        cfg_load = 1'b0;
  logic        tc_pulse;
  logic [3:0]  phase_code;
  logic        clk_out;

  int  tests = 0;
  int  fails = 0;
  int  cyc = 0;
  bit  done = 1'b0;
  logic last_clk_out;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fnd_divider u0 (
    .clk(clk), .rst_n(rst_n), .cfg_int(cfg_int), .cfg_frac(cfg_frac),
    .cfg_load(cfg_load), .tc_pulse(tc_pulse), .phase_code(phase_code),
    .clk_out(clk_out)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for the next tc_pulse sample; returns its cycle number
  task automatic wait_tc(output int t);
    int n = 0;
    t = -1;
    do begin
      @(negedge clk);
      n++;
    end while (!tc_pulse && n < 6000);
    if (!tc_pulse) begin
      fails++; tests++;
      $display("FAIL R3 actual=no pulse expected=pulse within 6000 cycles");
    end else t = cyc;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_load = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 tc_pulse in reset", tc_pulse, 0);
    check("R1 phase_code in reset", phase_code, 0);
    check("R1 clk_out in reset", clk_out, 0);
    rst_n = 1'b1;
  endtask

  task automatic load(input int n, input int f);
    cfg_int = 12'(n);
    cfg_frac = 20'(f);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  function automatic longint carry_k(input longint k, input longint f);
    return ((k * f) >> 20) - (((k - 1) * f) >> 20);
  endfunction

  function automatic longint phase_k(input longint k, input longint f);
    return ((k * f) % (64'd1 << 20)) >> 16;
  endfunction

  initial begin
    int t0, t1, trel;
    int neff;
    // directed: reset and first boundary
    do_reset();
    trel = cyc;
    wait_tc(t0);
    check("R1 first tc one edge after release", t0 - trel, 1);
    check("R5 clk_out after first tc", clk_out, 1);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wait_tc(t0);
      load(VN[v], VF[v]);
      wait_tc(t1);
      check("R7 period in progress keeps default length", t1 - t0, DEF_N);
      check("R4 phase after first update", phase_code, phase_k(1, VF[v]));
      neff = (VN[v] < 2) ? 2 : VN[v];
      for (int k = 1; k <= VK[v]; k++) begin
        last_clk_out = clk_out;
        t0 = t1;
        @(negedge clk);
        check("R3 pulse width one cycle", tc_pulse, 0);
        check("R5 clk_out holds between pulses", clk_out, last_clk_out);
        wait_tc(t1);
        if (VF[v] == 0)
          check("R8 zero fraction gives exact N", t1 - t0, neff);
        else if (VN[v] < 2)
          check("R6 clamped divide length", t1 - t0, neff + carry_k(k, VF[v]));
        else
          check("R2 period length N plus carry", t1 - t0, neff + carry_k(k, VF[v]));
        check("R4 phase code", phase_code, phase_k(k + 1, VF[v]));
        check("R5 clk_out toggled", clk_out, !last_clk_out);
      end
    end

    // directed: boundary lengths at the top of the range
    do_reset();
    wait_tc(t0);
    load(4095, 'hFFFFF);
    wait_tc(t0);
    wait_tc(t1);
    check("R8 largest period", t1 - t0, 4095);
    t0 = t1;
    wait_tc(t1);
    check("R8 largest period with carry", t1 - t0, 4096);

    // directed: load mid-stream is deferred to next boundary
    do_reset();
    wait_tc(t0);
    load(10, 0);
    wait_tc(t1);
    check("R7 default length before load applies", t1 - t0, DEF_N);
    load(4, 0);
    t0 = t1;
    wait_tc(t1);
    check("R7 current period unaffected by load", t1 - t0, 10);
    t0 = t1;
    wait_tc(t1);
    check("R7 new length after boundary", t1 - t0, 4);
    check("R4 phase with zero fraction", phase_code, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule